// File: doc/BRIEF.md
# PLL Frequency Change Sequencer

This block moves a CPU core clock between five performance levels. Level 0 is the fastest and level 4 the slowest: 1200, 1000, 800, 500 and 200 MHz. A request carries the current level and the target level and is accepted with a valid/ready handshake.

The controller then drives a fixed series of register-style strobes towards the clock hardware:
- It rewrites the two core divider words and waits for their busy status to clear.
- It rewrites the main PLL configuration word.
- When the PLL's multiplier or pre-divider must change, it first parks the core clock mux on a safe alternate PLL. It loads the lock-time counter, writes the new multiplier, pre-divider and post-divider, and waits for lock. It then returns the mux to the main PLL.
- When only the post-divider differs, it rewrites that field in place with no relock.

A move to a faster level updates the dividers before the PLL. A move to a slower level updates the PLL first.

The state machine has these states: `ST_IDLE`, `ST_DIV0_WR`, `ST_DIV0_WAIT`, `ST_DIV1_WR`, `ST_DIV1_WAIT`, `ST_S_WR`, `ST_PARK`, `ST_LOCK_LD`, `ST_PMS_WR`, `ST_LOCK_WAIT`, `ST_UNPARK` and `ST_DONE`. The transitions are:
- Accept: `ST_IDLE` goes to `ST_DONE` (same level), `ST_DIV0_WR` (faster), `ST_PARK` (slower, relock) or `ST_S_WR` (slower, post-divider only).
- Divider path: each `*_WR` state moves to its `*_WAIT` state.
- `ST_DIV1_WAIT` goes to `ST_DONE` if the PLL is already done, otherwise to the PLL path.
- `ST_S_WR` and `ST_UNPARK` go to `ST_DONE` if the dividers are already done, otherwise to `ST_DIV0_WR`.
- Relock path: `ST_PARK` goes to `ST_LOCK_LD`, then `ST_PMS_WR`, then `ST_LOCK_WAIT`, then `ST_UNPARK`.
- `ST_DONE` returns to `ST_IDLE`.
- Any wait state returns to `ST_IDLE` with the error flag set once its timeout expires.

Top module: `pll_level_sequencer`

## Requirements
- R1: `req_ready` is high exactly when the controller is idle, and `busy` is its complement. A request presented while busy is ignored and produces no strobe.
- R2: A request whose source level equals its target level reaches `ST_DONE` on the accepting edge, pulses `done` in the following cycle and issues no strobe.
- R3: A relock is needed exactly when the multiplier or the pre-divider differs between the two levels. Otherwise only the post-divider field is rewritten and the mux is never moved.
- R4: When the target index is below the source index, both divider writes come before any PLL activity.
- R5: When the target index is above the source index, all PLL activity comes before the divider writes.
- R6: PLL writes are read-modify-write on `pll_rd`. A full write replaces only bits 25:16 (multiplier), 13:8 (pre-divider) and 2:0 (post-divider). A post-divider-only write replaces only bits 2:0.
- R7: A relock runs in this order, with no step skipped:
  - raise `core_alt` and wait for `mux_stat` == 2;
  - pulse `lock_wr` with `lock_val` = LOCK_CYCLES;
  - write the PLL word;
  - wait for `pll_locked`;
  - drop `core_alt` and wait for `mux_stat` == 1.
- R8: A divider update does the following in order:
  - writes `div0_word`;
  - waits until `div0_stat` & 0x01111111 is zero, ignoring all other bits;
  - writes `div1_word`;
  - waits until `div1_stat` & 0x11 is zero.
- R9: Per-level settings (the fields of `div0_word` sit at bits 4k+2:4k, with k = 0..6):

  | Level | Multiplier | Pre-divider | Post-divider | `div0_word` fields, k = 0..6 | `div1_word` 6:4 | `div1_word` 2:0 |
  |---|---|---|---|---|---|---|
  | 0 | 150 | 3 | 1 | 0,3,7,3,4,1,7 | 5 | 0 |
  | 1 | 250 | 6 | 1 | 0,3,7,3,4,1,7 | 5 | 0 |
  | 2 | 200 | 6 | 1 | 0,3,7,3,3,1,7 | 5 | 0 |
  | 3 | 250 | 6 | 2 | 0,3,7,3,3,1,7 | 5 | 0 |
  | 4 | 200 | 6 | 3 | 0,1,3,1,3,1,0 | 3 | 0 |
- R10: A wait state whose condition stays false for `tmo_limit`+1 cycles causes the following:
  - the controller returns to idle;
  - `err` is set and stays set until the next accepted request;
  - no `done` pulse is given;
  - a timeout during `ST_PARK`, `ST_LOCK_WAIT` or `ST_UNPARK` leaves `core_alt` high.
- R11: Every completed change pulses `done` for exactly one cycle. After reset, `core_alt`, `err` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Change request valid |
| req_ready | output | 1 | Controller idle, request accepted |
| req_from | input | 3 | Current level |
| req_to | input | 3 | Target level |
| tmo_limit | input | TMO_W | Timeout per wait state, in cycles |
| busy | output | 1 | Change in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Sticky timeout flag |
| core_alt | output | 1 | 1 selects the safe alternate PLL on the core mux |
| mux_stat | input | 2 | Mux status, 1 = main PLL, 2 = alternate |
| lock_wr | output | 1 | Lock-time counter load strobe |
| lock_val | output | LOCK_W | Lock-time value |
| pll_wr | output | 1 | PLL configuration write strobe |
| pll_wr_data | output | 32 | PLL configuration write data |
| pll_rd | input | 32 | Current PLL configuration word |
| pll_locked | input | 1 | PLL lock flag |
| div0_wr | output | 1 | First divider word write strobe |
| div0_word | output | 32 | First divider word |
| div0_stat | input | 32 | First divider status |
| div1_wr | output | 1 | Second divider word write strobe |
| div1_word | output | 8 | Second divider word |
| div1_stat | input | 8 | Second divider status |

## Verification
The bench aims at the level pairs that share multiplier and pre-divider (1 and 3, 2 and 4). A design that relocked there would show a mux move the model does not expect. A design that skipped the relock for other pairs would write a new multiplier while `core_alt` is low. Each change is run in both directions, so swapping the divider and PLL order gives strobes out of the model's sequence. The status models keep bits outside the busy masks set, and the PLL word carries reserved bits that a careless rewrite would lose. A request held during a transfer must cause nothing, and a PLL that never locks must leave the mux parked with `err` high and no `done`.

// File: rtl/pls_pkg.sv
package pls_pkg;
    localparam int unsigned LVL_W = 3;
    localparam int unsigned CFG_W = 32;
    localparam int unsigned DIV1_W = 8;

    localparam logic [CFG_W-1:0]  DIV0_BUSY_MASK = 32'h0111_1111;
    localparam logic [DIV1_W-1:0] DIV1_BUSY_MASK = 8'h11;
    localparam logic [CFG_W-1:0]  PLL_MPS_MASK   = 32'h03FF_3F07;
    localparam logic [CFG_W-1:0]  PLL_S_MASK     = 32'h0000_0007;

    typedef enum logic [3:0] {
        ST_IDLE, ST_DIV0_WR, ST_DIV0_WAIT, ST_DIV1_WR, ST_DIV1_WAIT,
        ST_S_WR, ST_PARK, ST_LOCK_LD, ST_PMS_WR, ST_LOCK_WAIT,
        ST_UNPARK, ST_DONE
    } seq_state_e;

    typedef struct packed {
        logic [9:0]        m;
        logic [5:0]        p;
        logic [2:0]        s;
        logic [CFG_W-1:0]  div0;
        logic [DIV1_W-1:0] div1;
    } level_cfg_t;

    // seven 3-bit divider fields, field k at bits 4k+2:4k
    function automatic logic [CFG_W-1:0] pack_div0(
        input logic [2:0] f0, input logic [2:0] f1, input logic [2:0] f2,
        input logic [2:0] f3, input logic [2:0] f4, input logic [2:0] f5,
        input logic [2:0] f6);
        return {5'b0, f6, 1'b0, f5, 1'b0, f4, 1'b0, f3,
                1'b0, f2, 1'b0, f1, 1'b0, f0};
    endfunction

    function automatic logic [DIV1_W-1:0] pack_div1(input logic [2:0] hi,
                                                    input logic [2:0] lo);
        return {1'b0, hi, 1'b0, lo};
    endfunction
endpackage

// File: rtl/pls_level_table.sv
module pls_level_table
    import pls_pkg::*;
(
    input  logic [LVL_W-1:0] lvl,
    output level_cfg_t       cfg
);
    always_comb begin
        unique case (lvl)
            3'd0: cfg = '{m: 10'd150, p: 6'd3, s: 3'd1,
                          div0: pack_div0(3'd0, 3'd3, 3'd7, 3'd3, 3'd4, 3'd1, 3'd7),
                          div1: pack_div1(3'd5, 3'd0)};
            3'd1: cfg = '{m: 10'd250, p: 6'd6, s: 3'd1,
                          div0: pack_div0(3'd0, 3'd3, 3'd7, 3'd3, 3'd4, 3'd1, 3'd7),
                          div1: pack_div1(3'd5, 3'd0)};
            3'd2: cfg = '{m: 10'd200, p: 6'd6, s: 3'd1,
                          div0: pack_div0(3'd0, 3'd3, 3'd7, 3'd3, 3'd3, 3'd1, 3'd7),
                          div1: pack_div1(3'd5, 3'd0)};
            3'd3: cfg = '{m: 10'd250, p: 6'd6, s: 3'd2,
                          div0: pack_div0(3'd0, 3'd3, 3'd7, 3'd3, 3'd3, 3'd1, 3'd7),
                          div1: pack_div1(3'd5, 3'd0)};
            default: cfg = '{m: 10'd200, p: 6'd6, s: 3'd3,
                          div0: pack_div0(3'd0, 3'd1, 3'd3, 3'd1, 3'd3, 3'd1, 3'd0),
                          div1: pack_div1(3'd3, 3'd0)};
        endcase
    end
endmodule

// File: rtl/pls_wait_timer.sv
module pls_wait_timer #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic [CNT_W-1:0] limit,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clear)
            cnt_q <= '0;
        else if (cnt_q != {CNT_W{1'b1}})
            cnt_q <= cnt_q + 1'b1;
    end

    assign expired = (cnt_q >= limit);
endmodule

// File: rtl/pll_level_sequencer.sv
module pll_level_sequencer
    import pls_pkg::*;
#(
    parameter int unsigned TMO_W       = 16,
    parameter int unsigned LOCK_W      = 16,
    parameter int unsigned LOCK_CYCLES = 270
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [LVL_W-1:0]    req_from,
    input  logic [LVL_W-1:0]    req_to,
    input  logic [TMO_W-1:0]    tmo_limit,
    output logic                busy,
    output logic                done,
    output logic                err,
    output logic                core_alt,
    input  logic [1:0]          mux_stat,
    output logic                lock_wr,
    output logic [LOCK_W-1:0]   lock_val,
    output logic                pll_wr,
    output logic [CFG_W-1:0]    pll_wr_data,
    input  logic [CFG_W-1:0]    pll_rd,
    input  logic                pll_locked,
    output logic                div0_wr,
    output logic [CFG_W-1:0]    div0_word,
    input  logic [CFG_W-1:0]    div0_stat,
    output logic                div1_wr,
    output logic [DIV1_W-1:0]   div1_word,
    input  logic [DIV1_W-1:0]   div1_stat
);
    localparam logic [1:0] MUX_ON_MAIN = 2'd1;
    localparam logic [1:0] MUX_ON_ALT  = 2'd2;

    seq_state_e state_q, state_d;
    level_cfg_t src_cfg, dst_cfg, dst_q;
    logic       relock_q, div_done_q, pll_done_q, park_q, err_q;
    logic       mp_diff, tmo_hit, to_err, tmr_clear;
    logic [CFG_W-1:0] mps_field;

    pls_level_table u_src (.lvl(req_from), .cfg(src_cfg));
    pls_level_table u_dst (.lvl(req_to),   .cfg(dst_cfg));

    assign mp_diff   = ({src_cfg.m, src_cfg.p} != {dst_cfg.m, dst_cfg.p});
    assign tmr_clear = (state_d != state_q);

    pls_wait_timer #(.CNT_W(TMO_W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .clear(tmr_clear),
        .limit(tmo_limit), .expired(tmo_hit)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        to_err  = 1'b0;
        unique case (state_q)
            ST_IDLE: if (req_valid) begin
                if (req_from == req_to)    state_d = ST_DONE;
                else if (req_to < req_from) state_d = ST_DIV0_WR;
                else if (mp_diff)          state_d = ST_PARK;
                else                       state_d = ST_S_WR;
            end
            ST_DIV0_WR: state_d = ST_DIV0_WAIT;
            ST_DIV0_WAIT:
                if ((div0_stat & DIV0_BUSY_MASK) == '0) state_d = ST_DIV1_WR;
                else if (tmo_hit) begin to_err = 1'b1; state_d = ST_IDLE; end
            ST_DIV1_WR: state_d = ST_DIV1_WAIT;
            ST_DIV1_WAIT:
                if ((div1_stat & DIV1_BUSY_MASK) == '0)
                    state_d = pll_done_q ? ST_DONE : (relock_q ? ST_PARK : ST_S_WR);
                else if (tmo_hit) begin to_err = 1'b1; state_d = ST_IDLE; end
            ST_S_WR: state_d = div_done_q ? ST_DONE : ST_DIV0_WR;
            ST_PARK:
                if (mux_stat == MUX_ON_ALT) state_d = ST_LOCK_LD;
                else if (tmo_hit) begin to_err = 1'b1; state_d = ST_IDLE; end
            ST_LOCK_LD: state_d = ST_PMS_WR;
            ST_PMS_WR:  state_d = ST_LOCK_WAIT;
            ST_LOCK_WAIT:
                if (pll_locked) state_d = ST_UNPARK;
                else if (tmo_hit) begin to_err = 1'b1; state_d = ST_IDLE; end
            ST_UNPARK:
                if (mux_stat == MUX_ON_MAIN) state_d = div_done_q ? ST_DONE : ST_DIV0_WR;
                else if (tmo_hit) begin to_err = 1'b1; state_d = ST_IDLE; end
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register and request context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            dst_q      <= '0;
            relock_q   <= 1'b0;
            div_done_q <= 1'b0;
            pll_done_q <= 1'b0;
            park_q     <= 1'b0;
            err_q      <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && req_valid) begin
                dst_q      <= dst_cfg;
                relock_q   <= mp_diff;
                div_done_q <= 1'b0;
                pll_done_q <= 1'b0;
                err_q      <= 1'b0;
            end
            if (state_q == ST_DIV1_WR) div_done_q <= 1'b1;
            if (state_q == ST_S_WR || state_q == ST_PMS_WR) pll_done_q <= 1'b1;
            if (state_d == ST_PARK && state_q != ST_PARK) park_q <= 1'b1;
            if (state_d == ST_UNPARK && state_q != ST_UNPARK) park_q <= 1'b0;
            if (to_err) begin
                err_q <= 1'b1;
                if (state_q == ST_PARK || state_q == ST_LOCK_WAIT || state_q == ST_UNPARK)
                    park_q <= 1'b1;
            end
        end
    end

    assign mps_field = {6'b0, dst_q.m, 2'b0, dst_q.p, 5'b0, dst_q.s};

    // outputs
    always_comb begin
        req_ready = (state_q == ST_IDLE);
        busy      = (state_q != ST_IDLE);
        done      = (state_q == ST_DONE);
        err       = err_q;
        core_alt  = park_q;
        lock_wr   = (state_q == ST_LOCK_LD);
        lock_val  = LOCK_W'(LOCK_CYCLES);
        div0_wr   = (state_q == ST_DIV0_WR);
        div0_word = dst_q.div0;
        div1_wr   = (state_q == ST_DIV1_WR);
        div1_word = dst_q.div1;
        pll_wr    = (state_q == ST_S_WR) || (state_q == ST_PMS_WR);
        if (state_q == ST_S_WR)
            pll_wr_data = (pll_rd & ~PLL_S_MASK) | {{(CFG_W-3){1'b0}}, dst_q.s};
        else
            pll_wr_data = (pll_rd & ~PLL_MPS_MASK) | mps_field;
    end

    // R1: an accepted request makes the block busy on the next cycle
    p_accept_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> busy);
    // R11: completion is a single-cycle pulse
    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R3: multiplier and pre-divider never change while the core runs on the main PLL
    p_mp_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pll_wr && !core_alt) |-> (pll_wr_data[25:8] == pll_rd[25:8]));
    // R7: the mux returns to the main PLL only after lock was seen
    p_unpark_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(core_alt) |-> $past(pll_locked));
    // R8: second divider word only after first status cleared
    p_div_order_r8: assert property (@(posedge clk) disable iff (!rst_n)
        div1_wr |-> (($past(div0_stat) & DIV0_BUSY_MASK) == '0));
    // R10: an error always lands in idle without a done pulse
    p_err_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> (req_ready && !done));
endmodule

// File: tb/pll_level_sequencer_test.sv
`timescale 1ns/1ps
module pll_level_sequencer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_ready;
    logic [2:0]  req_from = '0, req_to = '0;
    logic [15:0] tmo_limit = 16'd20;
    logic        busy, done, err, core_alt;
    logic [1:0]  mux_stat;
    logic        lock_wr, pll_wr, pll_locked, div0_wr, div1_wr;
    logic [15:0] lock_val;
    logic [31:0] pll_wr_data, pll_rd, div0_word, div0_stat;
    logic [7:0]  div1_word, div1_stat;

    always #4 clk = ~clk;

    pll_level_sequencer uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_from(req_from), .req_to(req_to), .tmo_limit(tmo_limit),
        .busy(busy), .done(done), .err(err), .core_alt(core_alt),
        .mux_stat(mux_stat), .lock_wr(lock_wr), .lock_val(lock_val),
        .pll_wr(pll_wr), .pll_wr_data(pll_wr_data), .pll_rd(pll_rd),
        .pll_locked(pll_locked), .div0_wr(div0_wr), .div0_word(div0_word),
        .div0_stat(div0_stat), .div1_wr(div1_wr), .div1_word(div1_word),
        .div1_stat(div1_stat)
    );

    int total = 0, bad = 0, done_cnt = 0, cyc = 0;
    string cur_tag = "R1";

    // ---------------- hardware models ----------------
    logic [31:0] pll_reg = 32'h8000_4000 | (32'd150 << 16) | (32'd3 << 8) | 32'd1;
    int  lk_cnt = 0;
    bit  no_lock = 0;
    initial pll_locked = 1'b1;
    assign pll_rd = pll_reg;
    always @(posedge clk) begin
        if (pll_wr) begin pll_reg <= pll_wr_data; pll_locked <= 1'b0; lk_cnt <= 5; end
        else if (lk_cnt > 0) begin
            lk_cnt <= lk_cnt - 1;
            if (lk_cnt == 1 && !no_lock) pll_locked <= 1'b1;
        end
    end

    int mux_hold = 0;
    logic alt_seen = 1'b0;
    always @(posedge clk) begin
        if (!rst_n) begin mux_stat <= 2'd1; mux_hold <= 0; alt_seen <= 1'b0; end
        else if (core_alt != alt_seen) begin alt_seen <= core_alt; mux_stat <= 2'd0; mux_hold <= 3; end
        else if (mux_hold > 1) mux_hold <= mux_hold - 1;
        else if (mux_hold == 1) begin mux_hold <= 0; mux_stat <= alt_seen ? 2'd2 : 2'd1; end
    end

    int d0_cnt = 0, d1_cnt = 0;
    always @(posedge clk) begin
        if (div0_wr) d0_cnt <= 4; else if (d0_cnt > 0) d0_cnt <= d0_cnt - 1;
        if (div1_wr) d1_cnt <= 3; else if (d1_cnt > 0) d1_cnt <= d1_cnt - 1;
    end
    assign div0_stat = 32'h8000_0004 | ((d0_cnt != 0) ? 32'h0101_0010 : 32'h0);
    assign div1_stat = 8'h22 | ((d1_cnt != 0) ? 8'h11 : 8'h00);

    // ---------------- reference model ----------------
    int exp_kind[$];
    logic [31:0] exp_data[$];
    logic [31:0] exp_pll = 32'h8000_4000 | (32'd150 << 16) | (32'd3 << 8) | 32'd1;
    int tm[5] = '{150, 250, 200, 250, 200};
    int tp[5] = '{3, 6, 6, 6, 6};
    int ts[5] = '{1, 1, 1, 2, 3};

    function automatic logic [31:0] div0_of(int l);
        int f[7];
        logic [31:0] w = 0;
        if (l == 4) f = '{0, 1, 3, 1, 3, 1, 0};
        else        f = '{0, 3, 7, 3, (l < 2) ? 4 : 3, 1, 7};
        for (int k = 0; k < 7; k++) w = w | (32'(f[k]) << (4 * k));
        return w;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h (t=%0t)", req, act, expv, $time);
        end
    endtask

    task automatic push(int kind, logic [31:0] d);
        exp_kind.push_back(kind);
        exp_data.push_back(d);
    endtask

    task automatic push_div(int l);
        push(1, div0_of(l));                 // R8 first word
        push(2, 32'(((l == 4) ? 3 : 5) << 4)); // R8 second word
    endtask

    task automatic push_pll(int from, int to, bit stall);
        bit relock = (tm[from] != tm[to]) || (tp[from] != tp[to]);
        if (relock) begin
            push(5, 0);
            push(4, 32'd270);
            exp_pll = (exp_pll & ~32'h03FF_3F07) | (32'(tm[to]) << 16) |
                      (32'(tp[to]) << 8) | 32'(ts[to]);
            push(3, exp_pll);
            if (!stall) push(6, 0);
        end else begin
            exp_pll = (exp_pll & ~32'h7) | 32'(ts[to]);
            push(3, exp_pll);
        end
    endtask

    task automatic chk_evt(int kind, logic [31:0] d);
        int ek;
        logic [31:0] ed;
        if (exp_kind.size() == 0) begin
            check(0, {cur_tag, " unexpected strobe"}, 32'(kind), 32'h0);
            return;
        end
        ek = exp_kind.pop_front();
        ed = exp_data.pop_front();
        check(ek == kind, {cur_tag, " strobe order"}, 32'(kind), 32'(ek));
        if (kind == 3)      check(d == ed, {cur_tag, " R6 R9 pll word"}, d, ed);
        else if (kind <= 2) check(d == ed, {cur_tag, " R8 R9 divider word"}, d, ed);
        else if (kind == 4) check(d == ed, {cur_tag, " R7 lock value"}, d, ed);
    endtask

    logic alt_prev = 1'b0;
    always @(negedge clk) begin
        if (!rst_n) alt_prev = core_alt;
        else begin
            if (div0_wr) chk_evt(1, div0_word);
            if (div1_wr) chk_evt(2, {24'b0, div1_word});
            if (pll_wr)  chk_evt(3, pll_wr_data);
            if (lock_wr) chk_evt(4, {16'b0, lock_val});
            if (core_alt !== alt_prev) chk_evt(core_alt ? 5 : 6, 0);
            alt_prev = core_alt;
            if (done) done_cnt++;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            total++; bad++;
            $display("FAIL watchdog: actual=%0d expected<150000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    task automatic wait_idle(input bit drop_valid);
        int n = 0;
        while (!req_ready && n < 500) begin
            @(negedge clk); n++;
        end
        if (drop_valid) req_valid = 1'b0;
        check(req_ready, {cur_tag, " R1 return to idle"}, 32'(req_ready), 32'd1);
    endtask

    task automatic run(int from, int to, string tag, bit poke);
        cur_tag = tag;
        done_cnt = 0;
        if (from == to) begin end
        else if (to < from) begin push_div(to); push_pll(from, to, 0); end
        else begin push_pll(from, to, 0); push_div(to); end
        @(negedge clk);
        check(req_ready && !busy, {tag, " R1 ready when idle"}, {busy, req_ready}, 32'd1);
        req_from = 3'(from); req_to = 3'(to); req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check(busy && !req_ready, {tag, " R1 busy after accept"}, {busy, req_ready}, 32'd2);
        if (from == to)
            check(done, {tag, " R2 immediate done"}, 32'(done), 32'd1);
        if (poke) begin
            repeat (3) @(negedge clk);
            req_from = 3'd0; req_to = 3'd4; req_valid = 1'b1;   // R1 must be ignored
            @(negedge clk);
            check(!req_ready, "R1 ignored while busy", 32'(req_ready), 32'd0);
        end
        wait_idle(poke);
        repeat (10) @(negedge clk);
        check(req_ready && !busy, {tag, " R1 stays idle"}, {busy, req_ready}, 32'd1);
        check(done_cnt == 1, {tag, " R11 single done"}, 32'(done_cnt), 32'd1);
        check(exp_kind.size() == 0, {tag, " missing strobes"}, 32'(exp_kind.size()), 32'd0);
        check(!err && !core_alt, {tag, " R10 no error"}, {err, core_alt}, 32'd0);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready && !busy && !done, "R1 reset idle", {busy, done, req_ready}, 32'd1);
        check(!err && !core_alt, "R11 reset outputs", {err, core_alt}, 32'd0);
        check(!pll_wr && !div0_wr && !div1_wr && !lock_wr, "R11 reset strobes",
              {pll_wr, div0_wr, div1_wr, lock_wr}, 32'd0);
    endtask

    initial begin
        do_reset();
        run(0, 0, "R2", 0);
        run(0, 2, "R5 R7 R3", 0);
        run(2, 4, "R5 R3 R6", 0);
        run(4, 2, "R4 R3 R6", 0);
        run(2, 0, "R4 R7", 0);
        run(0, 3, "R5 R7", 0);
        run(3, 1, "R4 R3", 0);
        run(1, 4, "R5 R1", 1);
        run(4, 4, "R2", 0);

        // R10: PLL never locks during a faster relock 4 -> 1
        cur_tag = "R10";
        no_lock = 1;
        done_cnt = 0;
        push_div(1);
        push_pll(4, 1, 1);
        @(negedge clk);
        req_from = 3'd4; req_to = 3'd1; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        wait_idle(0);
        repeat (5) @(negedge clk);
        check(err, "R10 error flag", 32'(err), 32'd1);
        check(core_alt, "R10 mux left on safe PLL", 32'(core_alt), 32'd1);
        check(done_cnt == 0, "R10 no done", 32'(done_cnt), 32'd0);
        check(exp_kind.size() == 0, "R10 strobes before timeout", 32'(exp_kind.size()), 32'd0);
        no_lock = 0;
        do_reset();
        run(1, 0, "R4 R7", 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule